// File: doc/BRIEF.md
# Power Management Event and Timer Register Block

This block holds a small set of fixed power management registers. A free-running timer advances once for every cycle in which the tick-enable input is high, where that input runs at the power management timer rate. The timer is read through the register bus with its unused upper bits zero. A timer overflow flag and a power button flag sit in a status register. That register is paired with an enable register, and together they drive a level-sensitive system control interrupt (SCI). Software clears flags by writing ones to them.

A control register holds the SCI-enable bit and the suspend type field. Setting the self-clearing suspend-enable bit with a type of zero produces a one-cycle soft-off request. Two byte ports carry the legacy power management command and status bytes. A write to the command port can raise a one-cycle SMI pulse when the SMI-enable configuration input is high. Two fixed command codes turn SCI enable on or off.

All registers are written with `bus_wr`, `bus_addr` and `bus_wdata` on a rising clock edge. Reads are combinational from `bus_addr`. Clock generation, address decode above the block, and power sequencing are outside it.

Top module: `pm_evt_regs`

## Requirements
- R1: The timer is `TMR_W` bits wide. It increments by one on each clock edge where `tick_en` is high, wraps to zero, and holds otherwise. It reads at offset 0x08, zero-extended to 32 bits.
- R2: Reset clears every register, the timer and all outputs. The offsets are: status 0x00, enable 0x02, control 0x04, timer 0x08, command byte 0x10, status byte 0x11. Any other offset reads 0.
- R3: Status bit 0 (timer overflow) sets on the tick that moves the timer's low `TMR_W-1` bits from all ones to zero. This is every 2^(`TMR_W-1`) ticks, whatever the enable register holds.
- R4: A write to offset 0x00 clears each status bit written as 1 and leaves bits written as 0 unchanged. A hardware event that sets a bit in the same cycle wins over the clear.
- R5: A cycle with `pwrbtn_evt` high sets status bit 8 only when enable bit 8 is already 1.
- R6: `sci` is high exactly while some bit among 10, 8, 5 and 0 is 1 in both the status and enable registers.
- R7: Control bit 13 is never stored and reads 0. A control write with bit 13 set and bits 12:10 equal to 0 makes `soft_off` high for the single cycle after the write. Any other type value gives no pulse. All other control bits are stored as written.
- R8: A write to the command byte at 0x10 stores the byte. The value 0xF1 sets control bit 0, 0xF0 clears it, and any other value leaves it unchanged.
- R9: Each command byte write makes `smi` high for the single cycle after the write when `smi_cfg_en` is high at the write, and leaves it low otherwise. The status byte at 0x11 is plain read/write storage.
- R10: The enable register stores and reads back all 16 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset for read and write |
| bus_wdata | input | 16 | Write data; byte ports use bits 7:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tick_en | input | 1 | Timer advance enable at the timer rate |
| pwrbtn_evt | input | 1 | Power button event |
| smi_cfg_en | input | 1 | Allows command byte writes to raise SMI |
| sci | output | 1 | Level SCI interrupt |
| smi | output | 1 | One-cycle SMI pulse |
| soft_off | output | 1 | One-cycle soft-off request |

## Verification
The bench builds the block with `TMR_W` set to 12, so the overflow flag sets every 2048 ticks. Several overflows and one full timer wrap then fit into a short run. The run includes overflows that coincide with status clears and with enable changes. The default width of 24 leaves the logic unchanged but would need over eight million ticks per overflow.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_STS     = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_EN      = 6'h02;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_TMR     = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_APM_CMD = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_APM_STS = 6'h11;

    localparam int BIT_TMR_OVF = 0;
    localparam int BIT_GBL     = 5;
    localparam int BIT_PWRBTN  = 8;
    localparam int BIT_RTC     = 10;

    localparam logic [REG_W-1:0] SCI_SRC_MASK =
        REG_W'((1 << BIT_TMR_OVF) | (1 << BIT_GBL) | (1 << BIT_PWRBTN) | (1 << BIT_RTC));

    localparam int CTRL_SCI_EN  = 0;
    localparam int CTRL_SUSP_EN = 13;
    localparam int CTRL_TYP_LO  = 10;
    localparam int TYP_W        = 3;
    localparam logic [TYP_W-1:0] SUSP_TYPE_OFF = '0;

    localparam logic [BYTE_W-1:0] APM_CMD_ON  = 8'hF1;
    localparam logic [BYTE_W-1:0] APM_CMD_OFF = 8'hF0;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
    } evt_state_t;

    typedef struct packed {
        logic [REG_W-1:0]  ctrl;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] apms;
        logic              soft_off;
        logic              smi;
    } apm_state_t;

endpackage

// File: rtl/pm_evt_timer.sv
module pm_evt_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [TMR_W-1:0] count,
    output logic             ovf_evt
);
    localparam int LOW_W = TMR_W - 1;

    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        ovf_evt = 1'b0;
        if (tick_en) begin
            cnt_d   = cnt_q + TMR_W'(1);
            // the top bit flips exactly when the low bits roll over
            ovf_evt = &cnt_q[LOW_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
    import pm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             pwrbtn_evt,
    input  logic             ovf_evt,
    output logic [REG_W-1:0] sts,
    output logic [REG_W-1:0] en,
    output logic             sci
);
    evt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_sts) s_d.sts = s_q.sts & ~wdata;
        if (wr_en)  s_d.en  = wdata;
        // hardware events come after the clear so they take priority
        if (ovf_evt)                          s_d.sts[BIT_TMR_OVF] = 1'b1;
        if (pwrbtn_evt && s_q.en[BIT_PWRBTN]) s_d.sts[BIT_PWRBTN]  = 1'b1;
        s_d.sts = s_d.sts & SCI_SRC_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sts = s_q.sts;
    assign en  = s_q.en;
    assign sci = |(s_q.sts & s_q.en & SCI_SRC_MASK);

endmodule

// File: rtl/pm_evt_apm_ctrl.sv
module pm_evt_apm_ctrl
    import pm_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_cmd,
    input  logic              wr_apms,
    input  logic [REG_W-1:0]  wdata,
    input  logic              smi_cfg_en,
    output logic [REG_W-1:0]  ctrl,
    output logic [BYTE_W-1:0] cmd,
    output logic [BYTE_W-1:0] apms,
    output logic              soft_off,
    output logic              smi
);
    apm_state_t a_d, a_q;

    always_comb begin
        a_d          = a_q;
        a_d.soft_off = 1'b0;
        a_d.smi      = 1'b0;
        if (wr_ctrl) begin
            a_d.ctrl               = wdata;
            a_d.ctrl[CTRL_SUSP_EN] = 1'b0;
            if (wdata[CTRL_SUSP_EN] && (wdata[CTRL_TYP_LO +: TYP_W] == SUSP_TYPE_OFF))
                a_d.soft_off = 1'b1;
        end
        if (wr_cmd) begin
            a_d.cmd = wdata[BYTE_W-1:0];
            if (wdata[BYTE_W-1:0] == APM_CMD_ON)
                a_d.ctrl[CTRL_SCI_EN] = 1'b1;
            else if (wdata[BYTE_W-1:0] == APM_CMD_OFF)
                a_d.ctrl[CTRL_SCI_EN] = 1'b0;
            a_d.smi = smi_cfg_en;
        end
        if (wr_apms) a_d.apms = wdata[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign ctrl     = a_q.ctrl;
    assign cmd      = a_q.cmd;
    assign apms     = a_q.apms;
    assign soft_off = a_q.soft_off;
    assign smi      = a_q.smi;

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
#(
    parameter int TMR_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    input  logic              pwrbtn_evt,
    input  logic              smi_cfg_en,
    output logic              sci,
    output logic              smi,
    output logic              soft_off
);
    logic [TMR_W-1:0]  tmr_q;
    logic              ovf_evt;
    logic [REG_W-1:0]  sts_q, en_q, ctrl_q;
    logic [BYTE_W-1:0] cmd_q, apms_q;

    logic wr_sts, wr_en, wr_ctrl, wr_cmd, wr_apms;
    assign wr_sts  = bus_wr && (bus_addr == OFS_STS);
    assign wr_en   = bus_wr && (bus_addr == OFS_EN);
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_cmd  = bus_wr && (bus_addr == OFS_APM_CMD);
    assign wr_apms = bus_wr && (bus_addr == OFS_APM_STS);

    pm_evt_timer #(.TMR_W(TMR_W)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count   (tmr_q),
        .ovf_evt (ovf_evt)
    );

    pm_evt_status sts_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sts     (wr_sts),
        .wr_en      (wr_en),
        .wdata      (bus_wdata),
        .pwrbtn_evt (pwrbtn_evt),
        .ovf_evt    (ovf_evt),
        .sts        (sts_q),
        .en         (en_q),
        .sci        (sci)
    );

    pm_evt_apm_ctrl apm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_cmd     (wr_cmd),
        .wr_apms    (wr_apms),
        .wdata      (bus_wdata),
        .smi_cfg_en (smi_cfg_en),
        .ctrl       (ctrl_q),
        .cmd        (cmd_q),
        .apms       (apms_q),
        .soft_off   (soft_off),
        .smi        (smi)
    );

    always_comb begin
        case (bus_addr)
            OFS_STS:     bus_rdata = DATA_W'(sts_q);
            OFS_EN:      bus_rdata = DATA_W'(en_q);
            OFS_CTRL:    bus_rdata = DATA_W'(ctrl_q);
            OFS_TMR:     bus_rdata = DATA_W'(tmr_q);
            OFS_APM_CMD: bus_rdata = DATA_W'(cmd_q);
            OFS_APM_STS: bus_rdata = DATA_W'(apms_q);
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pm_evt_regs_chk.sv
module pm_evt_regs_chk #(
    parameter int TMR_W  = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [5:0]        bus_addr,
    input logic [7:0]        wr_byte,
    input logic [3:0]        wr_susp,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_en,
    input logic              pwrbtn_evt,
    input logic              smi_cfg_en,
    input logic              sci,
    input logic              smi,
    input logic              soft_off,
    input logic [TMR_W-1:0]  tmr_q,
    input logic              sts_ovf,
    input logic              sts_pb,
    input logic              en_pb,
    input logic              ctrl_sci_en
);
    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(tmr_q)); // R1
    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> tmr_q == $past(tmr_q) + TMR_W'(1)); // R1
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 6'h06) |-> (bus_rdata == '0)); // R2
    AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (&tmr_q[TMR_W-2:0])) |=> sts_ovf); // R3
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_evt && en_pb) |=> sts_pb); // R4
    AST_PB_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_pb && !sts_pb) |=> !sts_pb); // R5
    AST_PB_SCI: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_evt && en_pb && !(bus_wr && bus_addr == 6'h02)) |=> sci); // R6
    AST_SUSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 6'h04) |-> !bus_rdata[13]); // R7
    AST_SOFTOFF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        soft_off |-> $past(bus_wr && bus_addr == 6'h04 && wr_susp == 4'b1000)); // R7
    AST_CMD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h10 && wr_byte == 8'hF1) |=> ctrl_sci_en); // R8
    AST_SMI_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> $past(bus_wr && bus_addr == 6'h10 && smi_cfg_en)); // R9
endmodule

bind pm_evt_regs pm_evt_regs_chk #(.TMR_W(TMR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .wr_byte     (bus_wdata[7:0]),
    .wr_susp     (bus_wdata[13:10]),
    .bus_rdata   (bus_rdata),
    .tick_en     (tick_en),
    .pwrbtn_evt  (pwrbtn_evt),
    .smi_cfg_en  (smi_cfg_en),
    .sci         (sci),
    .smi         (smi),
    .soft_off    (soft_off),
    .tmr_q       (tmr_q),
    .sts_ovf     (sts_q[0]),
    .sts_pb      (sts_q[8]),
    .en_pb       (en_q[8]),
    .ctrl_sci_en (ctrl_q[0])
);

// File: tb/pm_evt_regs_tb_top.sv
`timescale 1ns/1ps
module pm_evt_regs_tb_top;
    localparam int TW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        pwrbtn_evt = 1'b0;
    logic        smi_cfg_en = 1'b0;
    logic        sci, smi, soft_off;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // bench model, built from the requirements
    logic [TW-1:0] m_tmr = '0;
    logic [15:0]   m_sts = '0, m_en = '0, m_ctrl = '0;
    logic [7:0]    m_cmd = '0, m_apms = '0;
    logic          e_soft = 1'b0, e_smi = 1'b0;

    always #2 clk = ~clk;

    pm_evt_regs #(.TMR_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .pwrbtn_evt(pwrbtn_evt), .smi_cfg_en(smi_cfg_en), .sci(sci),
        .smi(smi), .soft_off(soft_off)
    );

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00:   return {16'h0, m_sts};
            6'h02:   return {16'h0, m_en};
            6'h04:   return {16'h0, m_ctrl};
            6'h08:   return 32'(m_tmr);
            6'h10:   return {24'h0, m_cmd};
            6'h11:   return {24'h0, m_apms};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_sci();
        return |(m_sts & m_en & 16'h0521);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [5:0] a, input string req);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic out_chk();
        chk("R6 sci level", {31'h0, sci}, {31'h0, exp_sci()});
        chk("R7 soft_off pulse", {31'h0, soft_off}, {31'h0, e_soft});
        chk("R9 smi pulse", {31'h0, smi}, {31'h0, e_smi});
    endtask

    // one clock: inputs applied after a falling edge, model advanced at the rising edge
    task automatic step(input logic wr, input logic [5:0] a, input logic [15:0] d,
                        input logic tk, input logic pb);
        logic ovf;
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk; pwrbtn_evt = pb;
        @(posedge clk);
        ovf    = tk && (&m_tmr[TW-2:0]);
        e_soft = 1'b0;
        e_smi  = 1'b0;
        if (pb && m_en[8]) m_sts[8] = 1'b1;
        if (wr && a == 6'h00) m_sts = m_sts & ~d;
        if (ovf)           m_sts[0] = 1'b1;
        if (pb && m_en[8]) m_sts[8] = 1'b1;
        if (tk) m_tmr = m_tmr + TW'(1);
        if (wr && a == 6'h02) m_en = d;
        if (wr && a == 6'h04) begin
            m_ctrl = d & 16'hDFFF;
            e_soft = d[13] && (d[12:10] == 3'd0);
        end
        if (wr && a == 6'h10) begin
            m_cmd = d[7:0];
            if (d[7:0] == 8'hF1) m_ctrl[0] = 1'b1;
            else if (d[7:0] == 8'hF0) m_ctrl[0] = 1'b0;
            e_smi = smi_cfg_en;
        end
        if (wr && a == 6'h11) m_apms = d[7:0];
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0; pwrbtn_evt = 1'b0;
        out_chk();
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state and undefined offsets
        out_chk();
        foreach (exp_read_ofs[i]) rd_chk(exp_read_ofs[i], "R2 reset/offset read");

        // R10: enable stores all bits
        step(1'b1, 6'h02, 16'hFFFF, 1'b0, 1'b0);
        rd_chk(6'h02, "R10 enable readback");

        // R5/R6: button with enable set
        step(1'b0, 6'h00, 16'h0, 1'b0, 1'b1);
        rd_chk(6'h00, "R5 button sets bit 8");
        chk("R6 sci after button", {31'h0, sci}, 32'h1);
        // R4: clear racing a new event, event wins
        step(1'b1, 6'h00, 16'h0100, 1'b0, 1'b1);
        rd_chk(6'h00, "R4 event wins over clear");
        step(1'b1, 6'h00, 16'h0100, 1'b0, 1'b0);
        rd_chk(6'h00, "R4 write-one clears");
        chk("R6 sci cleared", {31'h0, sci}, 32'h0);
        // R5: button masked
        step(1'b1, 6'h02, 16'h0000, 1'b0, 1'b0);
        step(1'b0, 6'h00, 16'h0, 1'b0, 1'b1);
        rd_chk(6'h00, "R5 masked button ignored");

        // R7: suspend enable
        step(1'b1, 6'h04, 16'h2000, 1'b0, 1'b0);
        chk("R7 soft_off type 0", {31'h0, soft_off}, 32'h1);
        rd_chk(6'h04, "R7 bit 13 reads 0");
        step(1'b1, 6'h04, 16'h2C01, 1'b0, 1'b0);
        chk("R7 no soft_off type 3", {31'h0, soft_off}, 32'h0);
        rd_chk(6'h04, "R7 control stored");

        // R8/R9: command codes and SMI
        smi_cfg_en = 1'b1;
        step(1'b1, 6'h10, 16'h00F0, 1'b0, 1'b0);
        rd_chk(6'h04, "R8 F0 clears SCI enable");
        chk("R9 smi with cfg", {31'h0, smi}, 32'h1);
        step(1'b1, 6'h10, 16'h0055, 1'b0, 1'b0);
        rd_chk(6'h04, "R8 other code leaves bit 0");
        rd_chk(6'h10, "R8 command byte stored");
        smi_cfg_en = 1'b0;
        step(1'b1, 6'h10, 16'h00F1, 1'b0, 1'b0);
        rd_chk(6'h04, "R8 F1 sets SCI enable");
        chk("R9 no smi without cfg", {31'h0, smi}, 32'h0);
        step(1'b1, 6'h11, 16'h00A5, 1'b0, 1'b0);
        rd_chk(6'h11, "R9 status byte");

        // R3/R1: run to an overflow with its enable set
        step(1'b1, 6'h02, 16'h0001, 1'b0, 1'b0);
        for (int i = 0; i < (1 << (TW - 1)); i++) step(1'b0, 6'h00, 16'h0, 1'b1, 1'b0);
        rd_chk(6'h00, "R3 overflow flag");
        rd_chk(6'h08, "R1 timer value");
        chk("R3 sci from overflow", {31'h0, sci}, 32'h1);

        // random phase
        for (int i = 0; i < 7000; i++) begin
            int op;
            logic [15:0] d;
            logic [5:0]  a;
            op = int'($urandom % 16);
            d  = 16'($urandom);
            if ((($urandom) % 32) == 0) smi_cfg_en = ~smi_cfg_en;
            case (op)
                0, 1: a = 6'h00;
                2:    a = 6'h02;
                3:    begin a = 6'h04; if ($urandom % 2 == 0) d[12:10] = 3'd0; end
                4:    begin a = 6'h10; if ($urandom % 2 == 0) d[7:0] = ($urandom % 2 == 0) ? 8'hF1 : 8'hF0; end
                5:    a = 6'h11;
                default: a = 6'($urandom);
            endcase
            step(op < 6, a, d, ($urandom % 4) != 0, ($urandom % 8) == 0);
            case ($urandom % 8)
                0: rd_chk(6'h00, "R4 status random");
                1: rd_chk(6'h02, "R10 enable random");
                2: rd_chk(6'h04, "R7 control random");
                3: rd_chk(6'h08, "R1 timer random");
                4: rd_chk(6'h10, "R8 command random");
                5: rd_chk(6'h11, "R9 status byte random");
                default: rd_chk(6'($urandom), "R2 any offset random");
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    localparam logic [5:0] exp_read_ofs [8] = '{6'h00, 6'h02, 6'h04, 6'h08, 6'h10, 6'h11, 6'h06, 6'h3F};

endmodule